// File: doc/BRIEF.md
# Dual-Pointer Data Memory with Ring Addressing

This block is the working data store of a fixed-program audio signal processor: a 128-word by 24-bit memory addressed through two 7-bit pointers, of which exactly one is active at any time. Each program instruction may carry one memory command on a small opcode input. That command can step the active pointer, hand control to the other pointer, load either pointer from the data bus, read the word under the active pointer, or write the bus word there. A read result appears on one registered output. The surrounding datapath routes that output to both the data bus and the multiplier operand selector.

A sample-start strobe marks the beginning of each audio sample period and puts both pointers back at their start positions. In linear mode the first pointer always starts at address 0. In ring mode it starts at a base that advances by one on every strobe, so a program written with fixed offsets walks through a circular delay line. The same base is added to any pointer value loaded from the bus while ring mode is on. All address arithmetic wraps modulo the memory depth.

Top module: `dmem_core`

## Requirements
- R1: After synchronous reset, pointer 0 reads 0, pointer 1 reads 64, pointer 0 is active (act_sel=0), ring_start is 0 and rd_valid is 0.
- R2: Opcodes on cmd_op are 0 no-op, 1 swap, 2/3/4 add 1/2/3 to the active pointer, 5/6/7 subtract 1/2/3 from it, 8 read, 9 load pointer 0, 10 load pointer 1, 11 write. A step changes only the active pointer, takes effect on the clock edge that accepts the command, and wraps modulo 128.
- R3: Swap makes the other pointer active and, on the same edge, adds 1 (mod 128) to the pointer that was active. The other pointer keeps its value.
- R4: In linear mode (ring_mode=0), load 0 or load 1 stores bus_in[6:0] unchanged in the named pointer, whichever pointer is active. The active selection does not change.
- R5: In ring mode, a load stores (bus_in[6:0] + ring_start) mod 128, where ring_start is pointer 0's start address for the current sample.
- R6: On sample_start, pointer 1 becomes 64 and pointer 0 becomes active. In ring mode pointer 0 and ring_start become N mod 128, where N counts the strobes since reset that came before this one. In linear mode both become 0.
- R7: A read command drives the word at the active pointer onto rd_data on the next clock, with rd_valid high for that one cycle. rd_valid is low after any cycle without a read.
- R8: A write command stores bus_in at the active pointer's value as it was before the edge, and leaves both pointers and the active selection unchanged.
- R9: Opcodes 12 to 15, and any cycle with cmd_valid low, change neither pointers, active selection nor memory contents.
- R10: When sample_start and a valid command arrive in the same cycle, the strobe takes effect and the command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_mode | input | 1 | 1 selects ring addressing, 0 linear |
| sample_start | input | 1 | Start-of-sample strobe |
| cmd_valid | input | 1 | cmd_op carries a command this cycle |
| cmd_op | input | 4 | Memory command opcode |
| bus_in | input | 24 | Data bus value for loads and writes |
| rd_data | output | 24 | Registered read word, to data bus and multiplier selector |
| rd_valid | output | 1 | rd_data holds a fresh read result |
| act_sel | output | 1 | Active pointer, 0 or 1 |
| ptr0 | output | 7 | Pointer 0 value |
| ptr1 | output | 7 | Pointer 1 value |
| ring_start | output | 7 | Pointer 0 start address for the current sample |

## Verification
The bench builds the block with its default parameters: 24-bit words, 7-bit addresses and a pointer 1 start of 64. With these values every wrap case is a few commands away: stepping below 0, a swap bump from 127, and a ring load whose sum passes 127. Ring behaviour is driven across a linear-mode strobe. This shows that the base counter keeps running while pointer 0 restarts at 0.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_SWAP  = 4'd1,
    OP_UP1   = 4'd2,
    OP_UP2   = 4'd3,
    OP_UP3   = 4'd4,
    OP_DN1   = 4'd5,
    OP_DN2   = 4'd6,
    OP_DN3   = 4'd7,
    OP_READ  = 4'd8,
    OP_LD0   = 4'd9,
    OP_LD1   = 4'd10,
    OP_WRITE = 4'd11
  } dmem_op_e;

  typedef struct packed {
    logic       swap;
    logic       step;
    logic       step_dn;
    logic [1:0] step_mag;
    logic       ld0;
    logic       ld1;
    logic       rd;
    logic       wr;
  } dmem_ctl_t;

endpackage

// File: rtl/dmem_cmd_decode.sv
module dmem_cmd_decode
  import dmem_pkg::*;
(
  input  logic       cmd_valid,
  input  logic       sample_start,
  input  logic [3:0] cmd_op,
  output dmem_ctl_t  ctl
);

  logic accept;
  assign accept = cmd_valid && !sample_start;

  always_comb begin
    ctl = '0;
    if (accept) begin
      case (cmd_op)
        OP_SWAP:  ctl.swap = 1'b1;
        OP_UP1:   begin ctl.step = 1'b1; ctl.step_mag = 2'd1; end
        OP_UP2:   begin ctl.step = 1'b1; ctl.step_mag = 2'd2; end
        OP_UP3:   begin ctl.step = 1'b1; ctl.step_mag = 2'd3; end
        OP_DN1:   begin ctl.step = 1'b1; ctl.step_dn = 1'b1; ctl.step_mag = 2'd1; end
        OP_DN2:   begin ctl.step = 1'b1; ctl.step_dn = 1'b1; ctl.step_mag = 2'd2; end
        OP_DN3:   begin ctl.step = 1'b1; ctl.step_dn = 1'b1; ctl.step_mag = 2'd3; end
        OP_READ:  ctl.rd  = 1'b1;
        OP_LD0:   ctl.ld0 = 1'b1;
        OP_LD1:   ctl.ld1 = 1'b1;
        OP_WRITE: ctl.wr  = 1'b1;
        default:  ctl = '0;
      endcase
    end
  end

endmodule

// File: rtl/dmem_ptr_unit.sv
module dmem_ptr_unit
  import dmem_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DP1_START = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ring_mode,
  input  logic              sample_start,
  input  dmem_ctl_t         ctl,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [ADDR_W-1:0] ptr0,
  output logic [ADDR_W-1:0] ptr1,
  output logic              act_sel,
  output logic [ADDR_W-1:0] ring_start,
  output logic [ADDR_W-1:0] act_addr
);

  localparam logic [ADDR_W-1:0] START1 = ADDR_W'(DP1_START);
  localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);

  logic [ADDR_W-1:0] ptr_q [2];
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] start_q;
  logic [ADDR_W-1:0] start_next;
  logic [ADDR_W-1:0] mag_w;
  logic [ADDR_W-1:0] delta;
  logic [ADDR_W-1:0] load_val;
  logic [1:0]        ld_v;

  assign start_next = ring_mode ? base_q : '0;
  assign mag_w      = ADDR_W'(ctl.step_mag);
  assign delta      = ctl.step_dn ? ('0 - mag_w) : mag_w;
  assign load_val   = ring_mode ? (bus_addr + start_q) : bus_addr;
  assign ld_v       = {ctl.ld1, ctl.ld0};

  // Ring base counter and the start address of the current sample
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      start_q <= '0;
    end else if (sample_start) begin
      base_q  <= base_q + ONE;
      start_q <= start_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               act_sel <= 1'b0;
    else if (sample_start) act_sel <= 1'b0;
    else if (ctl.swap)     act_sel <= ~act_sel;
  end

  for (genvar g = 0; g < 2; g++) begin : g_ptr
    localparam logic [ADDR_W-1:0] INIT = (g == 0) ? '0 : START1;
    logic              sel;
    logic [ADDR_W-1:0] p_q;
    logic [ADDR_W-1:0] restart;

    assign sel     = (act_sel == (g == 1));
    assign restart = (g == 0) ? start_next : START1;

    always_ff @(posedge clk) begin
      if (rst)                  p_q <= INIT;
      else if (sample_start)    p_q <= restart;
      else if (ld_v[g])         p_q <= load_val;
      else if (ctl.swap && sel) p_q <= p_q + ONE;
      else if (ctl.step && sel) p_q <= p_q + delta;
    end

    assign ptr_q[g] = p_q;
  end

  assign ptr0       = ptr_q[0];
  assign ptr1       = ptr_q[1];
  assign ring_start = start_q;
  assign act_addr   = act_sel ? ptr_q[1] : ptr_q[0];

  // R3: swap flips the selection and bumps the pointer being left
  p_swap_bump_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.swap |=> (act_sel != $past(act_sel)) &&
      (act_sel ? (ptr_q[0] == ADDR_W'($past(ptr_q[0]) + ONE)) && (ptr_q[1] == $past(ptr_q[1]))
               : (ptr_q[1] == ADDR_W'($past(ptr_q[1]) + ONE)) && (ptr_q[0] == $past(ptr_q[0]))));

  // R6: a strobe restarts both pointers and selects pointer 0
  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    sample_start |=> (ptr_q[1] == START1) && !act_sel && (ptr_q[0] == ring_start));

  // R6: the ring base advances by one per strobe
  p_base_step_r6: assert property (@(posedge clk) disable iff (rst)
    sample_start |=> base_q == ADDR_W'($past(base_q) + ONE));

  // R2: a step leaves the inactive pointer alone
  p_step_other_r2: assert property (@(posedge clk) disable iff (rst)
    ctl.step |=> $stable(act_sel) && (act_sel ? $stable(ptr_q[0]) : $stable(ptr_q[1])));

endmodule

// File: rtl/dmem_array.sv
module dmem_array #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Single-port array, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end

  // R7: read data is flagged exactly one clock after the request
  p_rd_latency_r7: assert property (@(posedge clk) disable iff (rst)
    re |=> rvalid);
  p_rd_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !re |=> !rvalid);

  // Read and write never share a cycle
  p_rw_excl: assert property (@(posedge clk) disable iff (rst)
    !(we && re));

endmodule

// File: rtl/dmem_core.sv
module dmem_core
  import dmem_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 24,
  parameter int DP1_START = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ring_mode,
  input  logic              sample_start,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              act_sel,
  output logic [ADDR_W-1:0] ptr0,
  output logic [ADDR_W-1:0] ptr1,
  output logic [ADDR_W-1:0] ring_start
);

  dmem_ctl_t         ctl;
  logic [ADDR_W-1:0] act_addr;

  dmem_cmd_decode u_dec (
    .cmd_valid    (cmd_valid),
    .sample_start (sample_start),
    .cmd_op       (cmd_op),
    .ctl          (ctl)
  );

  dmem_ptr_unit #(
    .ADDR_W    (ADDR_W),
    .DP1_START (DP1_START)
  ) u_ptr (
    .clk          (clk),
    .rst          (rst),
    .ring_mode    (ring_mode),
    .sample_start (sample_start),
    .ctl          (ctl),
    .bus_addr     (bus_in[ADDR_W-1:0]),
    .ptr0         (ptr0),
    .ptr1         (ptr1),
    .act_sel      (act_sel),
    .ring_start   (ring_start),
    .act_addr     (act_addr)
  );

  dmem_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk    (clk),
    .rst    (rst),
    .we     (ctl.wr),
    .re     (ctl.rd),
    .addr   (act_addr),
    .wdata  (bus_in),
    .rdata  (rd_data),
    .rvalid (rd_valid)
  );

  // R9: undefined opcodes touch no pointer state
  p_undef_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op > 4'd11) && !sample_start)
      |=> $stable(ptr0) && $stable(ptr1) && $stable(act_sel));

  // R9: idle cycles touch no pointer state
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid && !sample_start) |=> $stable(ptr0) && $stable(ptr1) && $stable(act_sel));

  // R8: a write leaves the pointers where they were
  p_wr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_op == OP_WRITE) && !sample_start)
      |=> $stable(ptr0) && $stable(ptr1) && $stable(act_sel));

  // R10: a strobe suppresses any read issued with it
  p_strobe_wins_r10: assert property (@(posedge clk) disable iff (rst)
    sample_start |=> !rd_valid);

endmodule

// File: tb/dmem_core_test.sv
module dmem_core_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ring_mode = 1'b0;
  logic        sample_start = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = 4'd0;
  logic [23:0] bus_in = '0;
  logic [23:0] rd_data;
  logic        rd_valid;
  logic        act_sel;
  logic [6:0]  ptr0, ptr1, ring_start;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  dmem_core uut (
    .clk (clk), .rst (rst), .ring_mode (ring_mode), .sample_start (sample_start),
    .cmd_valid (cmd_valid), .cmd_op (cmd_op), .bus_in (bus_in),
    .rd_data (rd_data), .rd_valid (rd_valid), .act_sel (act_sel),
    .ptr0 (ptr0), .ptr1 (ptr1), .ring_start (ring_start)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmd_valid = 1'b0; sample_start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive one cycle of stimulus; returns at the following falling edge
  task automatic cyc(input logic v, input logic [3:0] op, input logic [23:0] d, input logic s);
    cmd_valid = v; cmd_op = op; bus_in = d; sample_start = s;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'd0; sample_start = 1'b0;
  endtask

  task automatic op(input logic [3:0] o, input logic [23:0] d);
    cyc(1'b1, o, d, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ptr0", ptr0, 0);
    chk("R1 ptr1", ptr1, 64);
    chk("R1 act", act_sel, 0);
    chk("R1 ring_start", ring_start, 0);
    chk("R1 rd_valid", rd_valid, 0);
  endtask

  task automatic t_steps();
    do_reset();
    op(4'd4, 0); chk("R2 +3", ptr0, 3);
    op(4'd3, 0); chk("R2 +2", ptr0, 5);
    op(4'd2, 0); chk("R2 +1", ptr0, 6);
    op(4'd5, 0); chk("R2 -1", ptr0, 5);
    op(4'd6, 0); chk("R2 -2", ptr0, 3);
    op(4'd7, 0); chk("R2 -3", ptr0, 0);
    op(4'd5, 0); chk("R2 wrap down", ptr0, 127);
    op(4'd2, 0); chk("R2 wrap up", ptr0, 0);
    chk("R2 other untouched", ptr1, 64);
  endtask

  task automatic t_swap();
    do_reset();
    op(4'd1, 0);
    chk("R3 act after swap", act_sel, 1);
    chk("R3 ptr0 bumped", ptr0, 1);
    chk("R3 ptr1 kept", ptr1, 64);
    op(4'd3, 0); chk("R2 step on ptr1", ptr1, 66);
    chk("R2 ptr0 idle", ptr0, 1);
    op(4'd1, 0);
    chk("R3 act back", act_sel, 0);
    chk("R3 ptr1 bumped", ptr1, 67);
    chk("R3 ptr0 kept", ptr0, 1);
  endtask

  task automatic t_rw();
    do_reset();
    op(4'd9, 24'hABCD90); chk("R4 load0 low bits", ptr0, 16);
    op(4'd11, 24'h123456); chk("R8 write holds ptr", ptr0, 16);
    op(4'd2, 0);
    op(4'd11, 24'hFEDCBA);
    op(4'd5, 0);
    op(4'd8, 0);
    chk("R7 read data", rd_data, 24'h123456);
    chk("R7 rd_valid", rd_valid, 1);
    chk("R8 read holds ptr", ptr0, 16);
    @(negedge clk); chk("R7 rd_valid drops", rd_valid, 0);
    op(4'd2, 0); op(4'd8, 0); chk("R8 second word", rd_data, 24'hFEDCBA);
    op(4'd10, 24'h00007F); chk("R4 load1", ptr1, 127);
    chk("R4 load1 keeps act", act_sel, 0);
    chk("R4 load1 keeps ptr0", ptr0, 17);
    op(4'd1, 0); chk("R3 bump 17", ptr0, 18);
    op(4'd11, 24'h00AA55);
    op(4'd1, 0); chk("R3 bump wraps", ptr1, 0);
    op(4'd9, 24'h00007F);
    op(4'd8, 0); chk("R8 write via ptr1", rd_data, 24'h00AA55);
  endtask

  task automatic t_undef();
    logic [6:0] p0, p1;
    p0 = ptr0; p1 = ptr1;
    for (int k = 12; k < 16; k++) op(4'(k), 24'h5A5A5A);
    chk("R9 ptr0 held", ptr0, p0);
    chk("R9 ptr1 held", ptr1, p1);
    chk("R9 act held", act_sel, 0);
    cyc(1'b0, 4'd11, 24'h999999, 1'b0);
    cyc(1'b0, 4'd2, 0, 1'b0);
    chk("R9 invalid step", ptr0, p0);
    op(4'd8, 0); chk("R9 memory held", rd_data, 24'h00AA55);
  endtask

  task automatic t_ring();
    do_reset();
    ring_mode = 1'b1;
    cyc(1'b0, 0, 0, 1'b1);
    chk("R6 ring s0", ptr0, 0);
    chk("R6 ptr1 start", ptr1, 64);
    op(4'd2, 0);
    cyc(1'b0, 0, 0, 1'b1); chk("R6 ring s1", ptr0, 1);
    cyc(1'b0, 0, 0, 1'b1); chk("R6 ring s2", ptr0, 2);
    chk("R6 ring_start", ring_start, 2);
    op(4'd9, 24'h00007E); chk("R5 ring load wraps", ptr0, 0);
    op(4'd10, 24'h000005); chk("R5 ring load1", ptr1, 7);
    op(4'd1, 0); chk("R3 act before strobe", act_sel, 1);
    ring_mode = 1'b0;
    cyc(1'b0, 0, 0, 1'b1);
    chk("R6 act reset", act_sel, 0);
    chk("R6 linear start", ptr0, 0);
    chk("R6 ptr1 restart", ptr1, 64);
    op(4'd9, 24'h000005); chk("R4 linear load unchanged", ptr0, 5);
    ring_mode = 1'b1;
    cyc(1'b0, 0, 0, 1'b1); chk("R6 counter ran on", ptr0, 4);
  endtask

  task automatic t_collide();
    cyc(1'b1, 4'd4, 0, 1'b1);
    chk("R10 step dropped", ptr0, 5);
    cyc(1'b1, 4'd10, 24'h000011, 1'b1);
    chk("R10 load dropped", ptr1, 64);
    chk("R10 new start", ring_start, 6);
    cyc(1'b1, 4'd8, 0, 1'b1);
    chk("R10 read dropped", rd_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_steps();
    t_swap();
    t_rw();
    t_undef();
    t_ring();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule